// File: doc/BRIEF.md
# Cascaded Dual Vectored Interrupt Controller

This block merges two 32-line interrupt controllers into a single prioritised source. Each controller owns a bank of programmable vector slots. A slot holds an enable bit and a 5-bit source select. When a slot is enabled and its selected line is both pending and unmasked, that slot takes part in arbitration. Lines that no slot claims are still reported, but only as a coarse "something unvectored is pending on controller A or B" indication.

One registered vector-address word serves both controllers. Software reads this word and dispatches directly: either on the interrupt number of the winning vectored source, or on a flag that names which controller must be scanned. The per-controller raw status words (pending AND mask) are available for that scan. Slots are loaded through a single-cycle write port.

Top module: `dual_vic_top`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears every slot to disabled and makes vec_addr read 0x000 after that edge.
- R2: irq_out is high in the same cycle whenever any line on either controller is both pending (req) and unmasked (mask bit 1), and low otherwise.
- R3: stat_a equals req_a AND mask_a, and stat_b equals req_b AND mask_b, combinationally.
- R4: A vectored winner gives vec_addr = 0x100 | n. For controller A, n is the slot's 5-bit select. For controller B, n is 32 + select, so B line 0 is IRQ 32 (0x120) and B line 24 gives 0x138.
- R5: Within one controller, the enabled and hit slot with the lowest index wins.
- R6: Any vectored hit on controller A outranks every vectored hit on controller B.
- R7: A vectored hit on either controller outranks any unvectored pending line.
- R8: With no vectored hit, an unmasked pending line on A gives vec_addr = 0x200. Otherwise, one on B gives 0x400. A is checked before B, and the low bits read 0.
- R9: With no unmasked pending line anywhere, vec_addr = 0x000.
- R10: A slot whose selected line is masked, not pending, or whose enable is 0 has no effect on vec_addr.
- R11: vec_addr is registered. It shows the resolution of the inputs seen at the previous rising edge and holds until the next edge.
- R12: A write with cfg_we=1 at a rising edge loads {cfg_en, cfg_sel} into slot cfg_slot of controller cfg_ctrl (0 = A, 1 = B). Writing cfg_en=0 removes that slot from arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_a | input | 32 | Pending lines of controller A (IRQ 0..31) |
| req_b | input | 32 | Pending lines of controller B (IRQ 32..63) |
| mask_a | input | 32 | Per-line enable mask of controller A |
| mask_b | input | 32 | Per-line enable mask of controller B |
| cfg_we | input | 1 | Slot write strobe |
| cfg_ctrl | input | 1 | Controller select for the write (0 = A, 1 = B) |
| cfg_slot | input | 4 | Slot index for the write |
| cfg_en | input | 1 | Slot enable value written |
| cfg_sel | input | 5 | Slot source-line select written |
| irq_out | output | 1 | Any unmasked pending line |
| vec_addr | output | 11 | Registered shared vector word |
| stat_a | output | 32 | Raw status of controller A |
| stat_b | output | 32 | Raw status of controller B |

## Verification
The bench builds the block with its default 16 slots per controller. Populating slots 0, 3, 7 and 15 therefore reaches both the lowest and the highest slot index, and mixes slot order against line order so that slot priority and line numbering can be told apart. The 32-line width puts line 24 of controller B within reach, which checks the 0x138 encoding, and line 0 of B, which checks the IRQ 32 boundary.

// File: rtl/vic_pkg.sv
// Shared constants and types for the dual vectored interrupt controller.
// Assumes 32 source lines per controller and an 11-bit vector word.
package vic_pkg;
    localparam int SRC_N  = 32;
    localparam int SEL_W  = $clog2(SRC_N);
    localparam int VEC_W  = 11;

    localparam logic [VEC_W-1:0] VEC_NONE = 11'h000;
    localparam logic [VEC_W-1:0] VEC_HIT  = 11'h100;
    localparam logic [VEC_W-1:0] VEC_UNVA = 11'h200;
    localparam logic [VEC_W-1:0] VEC_UNVB = 11'h400;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } slot_t;
endpackage

// File: rtl/vic_slot_bank.sv
// Register bank of vector slots for one controller.
// Assumes writes are single-cycle strobes; reset clears every slot to disabled.
module vic_slot_bank
    import vic_pkg::*;
#(
    parameter int N_SLOTS = 16,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    output slot_t [N_SLOTS-1:0]     slots
);
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        // Load or clear one slot register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[s] <= '0;
            else if (we && (idx == IDX_W'(s)))
                slots[s] <= '{en: wr_en, sel: wr_sel};
        end
    end
endmodule

// File: rtl/vic_resolver.sv
// Finds the lowest-index enabled slot whose selected line is set in stat.
// Assumes stat is already pending AND mask; purely combinational.
module vic_resolver
    import vic_pkg::*;
#(
    parameter int N_SLOTS = 16
) (
    input  slot_t [N_SLOTS-1:0] slots,
    input  logic  [SRC_N-1:0]   stat,
    output logic                hit,
    output logic  [SEL_W-1:0]   hit_sel
);
    // Scan from the highest slot down so that the lowest index wins.
    always_comb begin
        hit     = 1'b0;
        hit_sel = '0;
        for (int s = N_SLOTS - 1; s >= 0; s--) begin
            if (slots[s].en && stat[slots[s].sel]) begin
                hit     = 1'b1;
                hit_sel = slots[s].sel;
            end
        end
    end
endmodule

// File: rtl/dual_vic_top.sv
// Two chained vectored interrupt controllers with one shared vector register.
// Priority: A vectored, B vectored, A unvectored, B unvectored.
// Assumes synchronous active-low reset; vec_addr lags the inputs by one edge.
module dual_vic_top
    import vic_pkg::*;
#(
    parameter int N_SLOTS = 16,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  req_a,
    input  logic [SRC_N-1:0]  req_b,
    input  logic [SRC_N-1:0]  mask_a,
    input  logic [SRC_N-1:0]  mask_b,
    input  logic              cfg_we,
    input  logic              cfg_ctrl,
    input  logic [IDX_W-1:0]  cfg_slot,
    input  logic              cfg_en,
    input  logic [SEL_W-1:0]  cfg_sel,
    output logic              irq_out,
    output logic [VEC_W-1:0]  vec_addr,
    output logic [SRC_N-1:0]  stat_a,
    output logic [SRC_N-1:0]  stat_b
);
    localparam int N_CTRL = 2;

    logic [SRC_N-1:0] stat_c [N_CTRL];
    logic             hit_c  [N_CTRL];
    logic [SEL_W-1:0] sel_c  [N_CTRL];
    logic [VEC_W-1:0] vec_nxt;

    for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
        slot_t [N_SLOTS-1:0] slots;

        // Raw status of this controller.
        assign stat_c[c] = (c == 0) ? (req_a & mask_a) : (req_b & mask_b);

        vic_slot_bank #(.N_SLOTS(N_SLOTS)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (cfg_we && (cfg_ctrl == 1'(c))),
            .idx    (cfg_slot),
            .wr_en  (cfg_en),
            .wr_sel (cfg_sel),
            .slots  (slots)
        );

        vic_resolver #(.N_SLOTS(N_SLOTS)) u_res (
            .slots   (slots),
            .stat    (stat_c[c]),
            .hit     (hit_c[c]),
            .hit_sel (sel_c[c])
        );
    end

    assign stat_a  = stat_c[0];
    assign stat_b  = stat_c[1];
    assign irq_out = (|stat_c[0]) || (|stat_c[1]);

    // Pick the overall winner and encode it.
    always_comb begin
        if (hit_c[0])
            vec_nxt = VEC_HIT | VEC_W'({1'b0, sel_c[0]});
        else if (hit_c[1])
            vec_nxt = VEC_HIT | VEC_W'({1'b1, sel_c[1]});
        else if (|stat_c[0])
            vec_nxt = VEC_UNVA;
        else if (|stat_c[1])
            vec_nxt = VEC_UNVB;
        else
            vec_nxt = VEC_NONE;
    end

    // Shared vector register, refreshed every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_addr <= VEC_NONE;
        else
            vec_addr <= vec_nxt;
    end
endmodule

// File: rtl/dual_vic_checker.sv
// Temporal checks on the ports of dual_vic_top, attached by bind.
module dual_vic_checker
    import vic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_N-1:0] req_a,
    input logic [SRC_N-1:0] req_b,
    input logic [SRC_N-1:0] mask_a,
    input logic [SRC_N-1:0] mask_b,
    input logic             irq_out,
    input logic [VEC_W-1:0] vec_addr,
    input logic [SRC_N-1:0] stat_a,
    input logic [SRC_N-1:0] stat_b
);
    // R1: a reset edge leaves the vector word at zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> vec_addr == VEC_NONE);

    // R3: status words follow request and mask.
    a_r3_status: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a == (req_a & mask_a)) && (stat_b == (req_b & mask_b)));

    // R9: no pending line yields an empty vector word next cycle.
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |=> vec_addr == VEC_NONE);

    // R11: a pending line yields a non-empty vector word next cycle.
    a_r11_lag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |=> vec_addr != VEC_NONE);

    // R8: at most one of the three flag bits is set.
    a_r8_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_addr[10:8]));

    // R8: unvectored B is reported only when A had nothing pending.
    a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr[10] |-> $past(stat_a) == '0);

    // R4: vectored words carry nothing above the 6-bit number but bit 8.
    a_r4_shape: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr[8] |-> vec_addr[7:6] == 2'b00);
endmodule

bind dual_vic_top dual_vic_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_a    (req_a),
    .req_b    (req_b),
    .mask_a   (mask_a),
    .mask_b   (mask_b),
    .irq_out  (irq_out),
    .vec_addr (vec_addr),
    .stat_a   (stat_a),
    .stat_b   (stat_b)
);

// File: tb/tb_dual_vic_top.sv
module tb_dual_vic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_a = '0, req_b = '0, mask_a = '0, mask_b = '0;
    logic        cfg_we = 1'b0, cfg_ctrl = 1'b0, cfg_en = 1'b0;
    logic [3:0]  cfg_slot = '0;
    logic [4:0]  cfg_sel = '0;
    logic        irq_out;
    logic [10:0] vec_addr;
    logic [31:0] stat_a, stat_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    dual_vic_top dut (
        .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
        .mask_a(mask_a), .mask_b(mask_b), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
        .cfg_slot(cfg_slot), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
        .irq_out(irq_out), .vec_addr(vec_addr), .stat_a(stat_a), .stat_b(stat_b)
    );

    always #2.5 clk = ~clk;

    localparam logic [31:0] ALL = 32'hFFFF_FFFF;
    // {req_a, req_b, mask_a, mask_b, expected vec, expected irq}
    localparam int NV = 14;
    localparam logic [139:0] TBL [NV] = '{
        {32'h0,        32'h0,        ALL,           ALL,           11'h000, 1'b0}, // R9
        {32'h20,       32'h0,        ALL,           ALL,           11'h105, 1'b1}, // R4
        {32'h4,        32'h0,        ALL,           ALL,           11'h102, 1'b1}, // R4
        {32'h24,       32'h0,        ALL,           ALL,           11'h105, 1'b1}, // R5
        {32'h0,        32'h0100_0000, ALL,          ALL,           11'h138, 1'b1}, // R4
        {32'h0,        32'h1,        ALL,           ALL,           11'h120, 1'b1}, // R4
        {32'h0,        32'h0100_0001, ALL,          ALL,           11'h138, 1'b1}, // R5
        {32'h4,        32'h0100_0000, ALL,          ALL,           11'h102, 1'b1}, // R6
        {32'h200,      32'h0100_0000, ALL,          ALL,           11'h138, 1'b1}, // R7
        {32'h200,      32'h0,        ALL,           ALL,           11'h200, 1'b1}, // R8
        {32'h0,        32'h200,      ALL,           ALL,           11'h400, 1'b1}, // R8
        {32'h200,      32'h200,      ALL,           ALL,           11'h200, 1'b1}, // R8
        {32'h220,      32'h0,        ~32'h20,       ALL,           11'h200, 1'b1}, // R10
        {32'h0,        32'h0100_0000, ALL,          ~32'h0100_0000, 11'h000, 1'b0}  // R2 R10
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_slot(logic ctrl, logic [3:0] idx, logic en, logic [4:0] sel);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctrl = ctrl; cfg_slot = idx; cfg_en = en; cfg_sel = sel;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(logic [31:0] ra, logic [31:0] rb, logic [31:0] ma, logic [31:0] mb);
        @(negedge clk);
        req_a = ra; req_b = rb; mask_a = ma; mask_b = mb;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        req_a = 32'h20; mask_a = ALL; mask_b = ALL;
        repeat (3) @(negedge clk);
        check("R1 vec in reset", 32'(vec_addr), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // slots cleared by reset: line 5 of A reports unvectored
        check("R1 slots disabled", 32'(vec_addr), 32'h200);

        // R12: program slots
        wr_slot(1'b0, 4'd3, 1'b1, 5'd5);
        wr_slot(1'b0, 4'd7, 1'b1, 5'd2);
        wr_slot(1'b1, 4'd0, 1'b1, 5'd24);
        wr_slot(1'b1, 4'd15, 1'b1, 5'd0);
        @(negedge clk);
        check("R12 slot load", 32'(vec_addr), 32'h105);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][139:108], TBL[i][107:76], TBL[i][75:44], TBL[i][43:12]);
            #1;
            check("R2 irq", 32'(irq_out), 32'(TBL[i][0]));
            check("R3 stat_a", stat_a, TBL[i][139:108] & TBL[i][75:44]);
            check("R3 stat_b", stat_b, TBL[i][107:76] & TBL[i][43:12]);
            @(negedge clk);
            check($sformatf("R4-table row %0d vec", i), 32'(vec_addr), 32'(TBL[i][11:1]));
        end

        // R11: registered update, value holds until the edge
        drive(32'h0, 32'h0, ALL, ALL);
        @(negedge clk);
        req_a = 32'h4;
        #1;
        check("R11 before edge", 32'(vec_addr), 32'h0);
        @(negedge clk);
        check("R11 after edge", 32'(vec_addr), 32'h102);

        // R10 / R12: disable slot 7 of A, line 2 becomes unvectored
        wr_slot(1'b0, 4'd7, 1'b0, 5'd2);
        @(negedge clk);
        check("R10 disabled slot", 32'(vec_addr), 32'h200);

        // R5: slot 15 of B still active at the top index
        drive(32'h0, 32'h1, ALL, ALL);
        @(negedge clk);
        check("R5 last slot", 32'(vec_addr), 32'h120);

        // R1: reset in operation clears vector word and slots
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", 32'(vec_addr), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 slots cleared", 32'(vec_addr), 32'h400);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule